// File: doc/BRIEF.md
# Burst SRAM Command Controller

This block takes one command at a time from a requesting engine and turns it into cycles on a synchronous single-port SRAM. There are three kinds of command. A burst read fetches 1 to 16 consecutive words and returns them one word per beat on a push-data output. A burst write first gathers all of its words from a pull-data input, where the source can stall, and then stores them in back-to-back SRAM cycles. An atomic command reads one word, adds an operand to it or ORs an operand into it, and writes the result back. It can also return the original value to the requester.

A two-bit configuration input adds 0 to 3 cycles to the SRAM's base read latency of 2 cycles. This lets the controller register read data correctly when pipeline registers sit between it and the memory. A single `done` strobe tells the requester that its command has completed. For reads and returning atomics it is raised on the final push beat. For writes it is raised on the final pull beat, before the stores begin. The atomic sequence takes no lock, and the SRAM port stays free between its read and its write.

Top module: `burst_sram_ctrl`

## Requirements
- R1: `cmd_ready` is high only when the controller is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the next cycle until the command has finished.
- R2: `cmd_op` encodes 0 = burst read, 1 = burst write, 2 = atomic add, 3 = atomic OR. `cmd_len` holds the word count minus one (0 means 1 word, 15 means 16). Word i of a burst uses address `cmd_addr + i`, which wraps modulo 2^ADDR_W.
- R3: A read drives `len+1` read cycles (`sram_en`=1, `sram_we`=0) in consecutive cycles. These start in the cycle right after acceptance, with the address going up by one each cycle.
- R4: Let D = `cfg_extra_dly`. Read word i appears on `push_data` with `push_valid` high exactly 3+D+i cycles after the acceptance edge, and the beats are consecutive.
- R5: For a read, `done` is high during the final push beat and at no other time in the command.
- R6: For a write, `pull_ready` is high from the cycle after acceptance until the last word is taken. A cycle with `pull_valid` low stalls the gathering. While gathering, and while idle, the SRAM is not accessed and `pull_valid` has no effect.
- R7: For a write, `done` is high exactly in the cycle of the final pull handshake.
- R8: After the final pull handshake, the write stores word i at `cmd_addr + i` in `len+1` consecutive write cycles, starting in the next cycle.
- R9: An atomic command affects one word and ignores `cmd_len`. It reads the word in the cycle after acceptance and writes old+operand (opcode 2) or old|operand (opcode 3) back to the same address 4+D cycles after acceptance.
- R10: If `cmd_ret` is set, an atomic pushes the original word with `push_valid` and `done` high 3+D cycles after acceptance. If `cmd_ret` is clear, nothing is pushed, and `done` is high during the write cycle.
- R11: The atomic takes no lock. `sram_en` is low for the 3+D cycles between its read cycle and its write cycle.
- R12: After reset, `cmd_ready` is high and `pull_ready`, `push_valid`, `done` and `sram_en` are low. This holds even if reset is applied in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 2 | Command kind (R2) |
| cmd_addr | input | ADDR_W | Start word address |
| cmd_len | input | LEN_W | Word count minus one |
| cmd_operand | input | DATA_W | Atomic operand |
| cmd_ret | input | 1 | Atomic: return the original word |
| cfg_extra_dly | input | DLY_W | Extra read-capture cycles |
| pull_valid | input | 1 | Write word offered by the source |
| pull_ready | output | 1 | Controller takes a write word |
| pull_data | input | DATA_W | Write word |
| push_valid | output | 1 | Read word on push_data |
| push_data | output | DATA_W | Returned word |
| done | output | 1 | Command completion strobe |
| sram_en | output | 1 | SRAM cycle enable |
| sram_we | output | 1 | SRAM write (else read) |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data |

## Verification
Every result has a fixed cycle offset from the acceptance edge:
- Read cycles fall at offsets 0..len.
- Push beat i falls at offset 3+D+i, and `cmd_ready` returns at offset 4+D+len.
- For an atomic, the read is at offset 0, the return beat at 3+D and the write at 4+D.
- For a write, the done strobe falls in the cycle of the last pull handshake, and the stores occupy the len+1 cycles after it.

The bench counts cycles from the acceptance edge. Each cycle it drives its inputs at the falling edge and samples one time unit later, comparing every output against the expected value for that offset. It repeats this for each delay setting and uses a memory image that it maintains itself.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the burst SRAM command controller.
// Assumes: a 2-bit opcode field; all users import this package.
package bsc_pkg;

    // Command kinds as carried on cmd_op
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ADD   = 2'd2,
        OP_OR    = 2'd3
    } bsc_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_DRAIN,
        ST_WR_PULL,
        ST_WR_STORE,
        ST_AT_RD,
        ST_AT_WAIT,
        ST_AT_WR
    } bsc_state_e;

    // Tag travelling alongside each outstanding SRAM read
    typedef struct packed {
        logic push;   // word goes out on the push port
        logic last;   // final beat of the command
    } bsc_tag_t;

endpackage

// File: rtl/bsc_read_pipe.sv
`timescale 1ns/1ps
// Module: bsc_read_pipe
// Tracks outstanding SRAM reads in a shift register. Each read registers
// sram_rdata after BASE_LAT + extra_dly cycles and carries a tag with it.
// Assumes: extra_dly is steady while reads are in flight; BASE_LAT >= 1.
module bsc_read_pipe
    import bsc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DLY_W    = 2,
    parameter int BASE_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  bsc_tag_t          launch_tag,
    input  logic [DLY_W-1:0]  extra_dly,
    input  logic [DATA_W-1:0] rdata,
    output logic              cap_valid,
    output bsc_tag_t          cap_tag,
    output logic [DATA_W-1:0] cap_data
);
    localparam int DEPTH = BASE_LAT + (1 << DLY_W) - 1;
    localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_sr;
    bsc_tag_t         tag_sr [DEPTH];
    logic [TAP_W-1:0] tap;

    // Pick the stage that matches the total read latency
    always_comb begin
        tap = TAP_W'(BASE_LAT - 1) + TAP_W'(extra_dly);
    end

    // Shift the valid/tag pair one stage per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                tag_sr[s] <= '0;
            end
        end else begin
            vld_sr[0] <= launch;
            tag_sr[0] <= launch_tag;
            for (int s = 1; s < DEPTH; s++) begin
                vld_sr[s] <= vld_sr[s-1];
                tag_sr[s] <= tag_sr[s-1];
            end
        end
    end

    // Register the returned word when its delay has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_tag   <= '0;
            cap_data  <= '0;
        end else begin
            cap_valid <= vld_sr[tap];
            if (vld_sr[tap]) begin
                cap_tag  <= tag_sr[tap];
                cap_data <= rdata;
            end
        end
    end
endmodule

// File: rtl/bsc_pull_buffer.sv
`timescale 1ns/1ps
// Module: bsc_pull_buffer
// Holds the words of one write burst between gathering and storing.
// Assumes: one write and one asynchronous read port; contents need no reset.
module bsc_pull_buffer #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] store [WORDS];

    // Capture an accepted pull word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Present the word for the current store cycle
    always_comb begin
        rd_data = store[rd_idx];
    end
endmodule

// File: rtl/bsc_atomic_alu.sv
`timescale 1ns/1ps
// Module: bsc_atomic_alu
// Computes the write-back value of an atomic command from the original word.
// Assumes: only the add and set-bits operations exist.
module bsc_atomic_alu #(
    parameter int DATA_W = 32
) (
    input  logic              use_or,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_word
);
    // Select the modify operation
    always_comb begin
        if (use_or) begin
            new_word = old_word | operand;
        end else begin
            new_word = old_word + operand;
        end
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
// Module: burst_sram_ctrl (top)
// Runs one burst read, burst write or atomic command at a time on a
// single-port synchronous SRAM. Reads return on the push port, writes are
// gathered from the pull port first, and done marks completion.
// Assumes: SRAM read data is valid BASE_LAT + cfg_extra_dly edges after the
// address edge; cfg_extra_dly is steady while a command runs.
module burst_sram_ctrl
    import bsc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 4,
    parameter int DLY_W    = 2,
    parameter int BASE_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_operand,
    input  logic              cmd_ret,
    input  logic [DLY_W-1:0]  cfg_extra_dly,
    input  logic              pull_valid,
    output logic              pull_ready,
    input  logic [DATA_W-1:0] pull_data,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              done,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata
);
    bsc_state_e        state_q;
    bsc_op_e           op_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [DATA_W-1:0] operand_q;
    logic              ret_q;

    logic              accept;
    logic              pull_fire;
    logic              idx_end;
    logic              launch;
    bsc_tag_t          launch_tag;
    logic              cap_valid;
    bsc_tag_t          cap_tag;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] buf_word;
    logic [DATA_W-1:0] atom_word;

    // Handshake and beat-position decodes
    always_comb begin
        accept    = cmd_valid & cmd_ready;
        pull_fire = pull_valid & pull_ready;
        idx_end   = (idx_q == len_q);
    end

    // Command sequencer: latch the command and step through its phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_READ;
            base_q    <= '0;
            len_q     <= '0;
            idx_q     <= '0;
            operand_q <= '0;
            ret_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= bsc_op_e'(cmd_op);
                        base_q    <= cmd_addr;
                        len_q     <= cmd_len;
                        operand_q <= cmd_operand;
                        ret_q     <= cmd_ret;
                        idx_q     <= '0;
                        unique case (bsc_op_e'(cmd_op))
                            OP_READ:  state_q <= ST_RD_ISSUE;
                            OP_WRITE: state_q <= ST_WR_PULL;
                            default:  state_q <= ST_AT_RD;
                        endcase
                    end
                end
                ST_RD_ISSUE: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_end) begin
                        state_q <= ST_RD_DRAIN;
                    end
                end
                ST_RD_DRAIN: begin
                    if (cap_valid && cap_tag.last) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WR_PULL: begin
                    if (pull_fire) begin
                        if (idx_end) begin
                            idx_q   <= '0;
                            state_q <= ST_WR_STORE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_WR_STORE: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_end) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_AT_RD: begin
                    state_q <= ST_AT_WAIT;
                end
                ST_AT_WAIT: begin
                    if (cap_valid) begin
                        state_q <= ST_AT_WR;
                    end
                end
                ST_AT_WR: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Handshake outputs derived from the phase
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        pull_ready = (state_q == ST_WR_PULL);
    end

    // SRAM port drive: enable, direction, address and write data
    always_comb begin
        sram_en    = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_STORE) ||
                     (state_q == ST_AT_RD)    || (state_q == ST_AT_WR);
        sram_we    = (state_q == ST_WR_STORE) || (state_q == ST_AT_WR);
        sram_addr  = base_q + ADDR_W'(idx_q);
        sram_wdata = (state_q == ST_AT_WR) ? atom_word : buf_word;
    end

    // Read launch and the tag that rides with it
    always_comb begin
        launch          = (state_q == ST_RD_ISSUE) || (state_q == ST_AT_RD);
        launch_tag.push = (state_q == ST_RD_ISSUE) ? 1'b1 : ret_q;
        launch_tag.last = (state_q == ST_RD_ISSUE) ? idx_end : 1'b1;
    end

    // Push port and completion strobe
    always_comb begin
        push_valid = cap_valid & cap_tag.push;
        push_data  = cap_data;
        done       = (push_valid & cap_tag.last) |
                     (pull_fire & idx_end) |
                     ((state_q == ST_AT_WR) & ~ret_q);
    end

    bsc_read_pipe #(
        .DATA_W   (DATA_W),
        .DLY_W    (DLY_W),
        .BASE_LAT (BASE_LAT)
    ) u_read_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_tag (launch_tag),
        .extra_dly  (cfg_extra_dly),
        .rdata      (sram_rdata),
        .cap_valid  (cap_valid),
        .cap_tag    (cap_tag),
        .cap_data   (cap_data)
    );

    bsc_pull_buffer #(
        .DATA_W (DATA_W),
        .IDX_W  (LEN_W)
    ) u_pull_buffer (
        .clk     (clk),
        .wr_en   (pull_fire),
        .wr_idx  (idx_q),
        .wr_data (pull_data),
        .rd_idx  (idx_q),
        .rd_data (buf_word)
    );

    bsc_atomic_alu #(
        .DATA_W (DATA_W)
    ) u_atomic_alu (
        .use_or   (op_q == OP_OR),
        .old_word (cap_data),
        .operand  (operand_q),
        .new_word (atom_word)
    );
endmodule

// File: rtl/bsc_checker.sv
`timescale 1ns/1ps
// Module: bsc_checker
// Protocol properties of burst_sram_ctrl, observed at its ports.
// Assumes: bound to every instance of the top module.
module bsc_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              pull_valid,
    input logic              pull_ready,
    input logic              push_valid,
    input logic              done,
    input logic              sram_en,
    input logic              sram_we,
    input logic [ADDR_W-1:0] sram_addr
);
    // R1: an accepted command closes the command port on the next cycle
    assert_one_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R1: when ready for a command, the SRAM and pull port are quiet
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!sram_en && !pull_ready));

    // R3: consecutive read cycles step the address by one
    assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && !sram_we && $past(sram_en && !sram_we))
            |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

    // R8: consecutive write cycles step the address by one
    assert_wr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we && $past(sram_en && sram_we))
            |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

    // R6: no SRAM or push activity while gathering write words
    assert_gather_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pull_ready |-> (!sram_en && !push_valid));

    // R7: during gathering, done only accompanies a pull handshake
    assert_pull_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pull_ready) |-> pull_valid);
endmodule

bind burst_sram_ctrl bsc_checker #(.ADDR_W(ADDR_W)) u_bsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .pull_valid (pull_valid),
    .pull_ready (pull_ready),
    .push_valid (push_valid),
    .done       (done),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for burst_sram_ctrl: a vector table walked by one loop, followed by
// directed reset and corner tests. Holds its own SRAM model and memory image.
module burst_sram_ctrl_bench;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int MW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid, cmd_ready, cmd_ret;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;
    logic [DW-1:0] cmd_operand;
    logic [1:0]    cfg_extra_dly;
    logic          pull_valid, pull_ready;
    logic [DW-1:0] pull_data;
    logic          push_valid;
    logic [DW-1:0] push_data;
    logic          done;
    logic          sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata, sram_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    burst_sram_ctrl u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_operand(cmd_operand),
        .cmd_ret(cmd_ret), .cfg_extra_dly(cfg_extra_dly),
        .pull_valid(pull_valid), .pull_ready(pull_ready), .pull_data(pull_data),
        .push_valid(push_valid), .push_data(push_data), .done(done),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // SRAM model: 2-cycle base read latency plus up to 3 external stages
    logic [DW-1:0] mem     [MW];
    logic [DW-1:0] ref_mem [MW];
    logic [DW-1:0] q1, q2;
    logic [DW-1:0] xs [4];
    int            ext_dly = 0;

    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         q1 <= mem[sram_addr];
        end
        q2    <= q1;
        xs[0] <= q2;
        for (int s = 1; s < 4; s++) xs[s] <= xs[s-1];
    end
    assign sram_rdata = (ext_dly == 0) ? q2 : xs[ext_dly-1];

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [DW-1:0] opnd;
        logic          ret;
        logic [1:0]    dly;
        logic          stall;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 10'h010, 4'd15, 32'h0,        1'b0, 2'd0, 1'b1},
        '{2'd0, 10'h010, 4'd15, 32'h0,        1'b0, 2'd0, 1'b0},
        '{2'd0, 10'h010, 4'd15, 32'h0,        1'b0, 2'd3, 1'b0},
        '{2'd0, 10'h3FE, 4'd3,  32'h0,        1'b0, 2'd1, 1'b0},
        '{2'd1, 10'h3FF, 4'd1,  32'h0,        1'b0, 2'd2, 1'b0},
        '{2'd0, 10'h3FF, 4'd1,  32'h0,        1'b0, 2'd2, 1'b0},
        '{2'd2, 10'h020, 4'd0,  32'h5,        1'b1, 2'd0, 1'b0},
        '{2'd3, 10'h020, 4'd0,  32'hF0000000, 1'b0, 2'd2, 1'b0},
        '{2'd0, 10'h020, 4'd0,  32'h0,        1'b0, 2'd1, 1'b0},
        '{2'd2, 10'h021, 4'd7,  32'hFFFFFFFF, 1'b1, 2'd3, 1'b0},
        '{2'd0, 10'h020, 4'd1,  32'h0,        1'b0, 2'd3, 1'b0}
    };

    task automatic check(input bit ok, input string req,
                         input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wword(int vi, int k);
        return 32'hA5000000 ^ (32'(vi) << 12) ^ (32'(k) * 32'h00010111);
    endfunction

    // Offer a command and return after the acceptance edge
    task automatic start_cmd(input vec_t v);
        @(negedge clk);
        cfg_extra_dly = v.dly;
        ext_dly       = int'(v.dly);
        cmd_valid     = 1'b1;
        cmd_op        = v.op;
        cmd_addr      = v.addr;
        cmd_len       = v.len;
        cmd_operand   = v.opnd;
        cmd_ret       = v.ret;
        #1;
        check(cmd_ready == 1'b1, "R1 ready before accept", 48'(cmd_ready), 48'd1);
        @(posedge clk);
    endtask

    task automatic run_read(input vec_t v);
        int d = int'(v.dly);
        int l = int'(v.len);
        start_cmd(v);
        for (int n = 0; n <= 4 + d + l; n++) begin
            int i;
            bit en_exp, pv_exp;
            logic [AW-1:0] a_exp;
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            en_exp = (n <= l);
            a_exp  = AW'(v.addr + AW'(n));
            check((sram_en == en_exp) && (!en_exp || (!sram_we && sram_addr == a_exp)),
                  "R2/R3 read cycle", {sram_en, sram_we, sram_addr},
                  {en_exp, 1'b0, en_exp ? a_exp : sram_addr});
            i = n - 3 - d;
            pv_exp = (i >= 0) && (i <= l);
            check(push_valid == pv_exp, "R4 push beat", 48'(push_valid), 48'(pv_exp));
            if (pv_exp) begin
                logic [DW-1:0] w = ref_mem[AW'(v.addr + AW'(i))];
                check(push_data == w, "R4 push data", 48'(push_data), 48'(w));
            end
            check(done == (i == l), "R5 read done", 48'(done), 48'(i == l));
            check(cmd_ready == (n == 4 + d + l), "R1 ready", 48'(cmd_ready), 48'(n == 4 + d + l));
        end
    endtask

    task automatic run_write(input vec_t v, input int vi);
        int l = int'(v.len);
        int k = 0;
        int n = 0;
        start_cmd(v);
        while (k <= l && n < 200) begin
            @(negedge clk);
            cmd_valid  = 1'b0;
            pull_valid = !(v.stall && (n % 3 == 1));
            pull_data  = wword(vi, k);
            #1;
            check(pull_ready && !sram_en, "R6 gathering", {pull_ready, sram_en}, 48'b10);
            check(done == (pull_valid && k == l), "R7 write done", 48'(done), 48'(pull_valid && k == l));
            check(!cmd_ready, "R1 busy", 48'(cmd_ready), 48'd0);
            if (pull_valid) k++;
            n++;
        end
        for (int j = 0; j <= l; j++) begin
            logic [AW-1:0] a_exp = AW'(v.addr + AW'(j));
            @(negedge clk);
            pull_valid = 1'b0;
            #1;
            check(sram_en && sram_we && sram_addr == a_exp && sram_wdata == wword(vi, j),
                  "R2/R8 store", {sram_en, sram_we, sram_addr, sram_wdata[35-AW:0]},
                  {2'b11, a_exp, wword(vi, j)[35-AW:0]});
            check(!done && !pull_ready, "R8 store quiet", {done, pull_ready}, 48'd0);
            ref_mem[a_exp] = wword(vi, j);
        end
        @(negedge clk);
        #1;
        check(cmd_ready && !sram_en, "R1 write finished", {cmd_ready, sram_en}, 48'b10);
    endtask

    task automatic run_atomic(input vec_t v);
        int d = int'(v.dly);
        logic [DW-1:0] old_w = ref_mem[v.addr];
        logic [DW-1:0] new_w = (v.op == 2'd3) ? (old_w | v.opnd) : (old_w + v.opnd);
        start_cmd(v);
        for (int n = 0; n <= 5 + d; n++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            if (n == 0)
                check(sram_en && !sram_we && sram_addr == v.addr, "R9 atomic read",
                      {sram_en, sram_we, sram_addr}, {2'b10, v.addr});
            if (n >= 1 && n <= 3 + d)
                check(!sram_en, "R11 port free", 48'(sram_en), 48'd0);
            if (n == 3 + d) begin
                check(push_valid == v.ret && done == v.ret, "R10 return beat",
                      {push_valid, done}, {v.ret, v.ret});
                if (v.ret) check(push_data == old_w, "R10 old value", 48'(push_data), 48'(old_w));
            end
            if (n == 4 + d) begin
                check(sram_en && sram_we && sram_addr == v.addr && sram_wdata == new_w,
                      "R9 write-back", {sram_en, sram_we, sram_addr, sram_wdata[35-AW:0]},
                      {2'b11, v.addr, new_w[35-AW:0]});
                check(done == !v.ret && !push_valid, "R10 done on write",
                      {done, push_valid}, {!v.ret, 1'b0});
            end
            if (n == 5 + d)
                check(cmd_ready, "R1 atomic finished", 48'(cmd_ready), 48'd1);
        end
        ref_mem[v.addr] = new_w;
    endtask

    task automatic check_reset_state(input string tag);
        check(cmd_ready && !pull_ready && !push_valid && !done && !sram_en, tag,
              {cmd_ready, pull_ready, push_valid, done, sram_en}, 48'b10000);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]     = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
            ref_mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
        end
        cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_len = 0; cmd_operand = 0;
        cmd_ret = 0; cfg_extra_dly = 0; pull_valid = 0; pull_data = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_reset_state("R12 reset state");

        // Vector table
        for (int vi = 0; vi < NV; vi++) begin
            vec_t v = VECS[vi];
            case (v.op)
                2'd0:    run_read(v);
                2'd1:    run_write(v, vi);
                default: run_atomic(v);
            endcase
        end

        // Directed: pull_valid while idle has no effect
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            pull_valid = 1'b1;
            pull_data  = 32'hDEADBEEF;
            #1;
            check(!done && !sram_en && !pull_ready, "R6 idle pull ignored",
                  {done, sram_en, pull_ready}, 48'd0);
        end
        pull_valid = 1'b0;
        run_read('{2'd0, 10'h010, 4'd2, 32'h0, 1'b0, 2'd0, 1'b0});

        // Directed: reset in the middle of a read burst
        start_cmd('{2'd0, 10'h100, 4'd15, 32'h0, 1'b0, 2'd1, 1'b0});
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check_reset_state("R12 mid-command reset");
        repeat (6) @(negedge clk);
        #1;
        check_reset_state("R12 held reset");
        rst_n = 1'b1;
        run_read('{2'd0, 10'h100, 4'd4, 32'h0, 1'b0, 2'd1, 1'b0});

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule